// File: doc/BRIEF.md
# Far-End Alarm Codeword Validator

This block watches a stream of far-end alarm and control (FEAC) codewords that an upstream deframer has already pulled out of the line. Each message arrives as a 6-bit code with a one-cycle strobe. The block keeps a sliding window of the most recent ten messages. It accepts a codeword once that codeword takes up eight of the ten window slots. It withdraws the acceptance once three of the ten slots hold some other code. Because the accept and withdraw levels differ, a noisy channel does not make the state chatter.

The accepted code is driven on its own output and stays there after a withdrawal. Software sees a single 8-bit control/status register. That register holds an "accepted" flag, two sticky event bits (accept and withdraw), one enable per event, and reserved bits. The event bits clear when the register is read. An interrupt line combines each event bit with its enable.

Top module: `feac_validator`

## Requirements
- R1: After reset the register reads 0x00, `val_code` is 0 and `irq` is low.
- R2: When the incoming code makes at least 8 of the last 10 strobed messages equal to it, and no code is accepted, register bit 4 reads 1 after the clock edge that takes in that message.
- R3: While a code is accepted, the message that brings the count of differing codes among the last 10 messages to 3 clears bit 4 at its clock edge. A removal and a validation never occur on the same message.
- R4: `val_code` takes the newly accepted code at the validation edge and otherwise holds its value, including after a removal.
- R5: Bit 0 is set by every validation and bit 2 by every removal, whatever the value of the matching enable.
- R6: A read strobe clears bits 0 and 2 at its clock edge. If an event coincides with the read, the event's bit ends up set.
- R7: A write stores wdata bit 3 as the removal enable and wdata bit 1 as the validation enable. Bits 0, 2 and 4 ignore written data. Bits 7 to 5 always read 0. Without a write the enables hold.
- R8: `irq` is high exactly when (bit 0 and bit 1) or (bit 2 and bit 3).
- R9: Cycles without a strobe leave the window and the flag unchanged. After a removal, a new code is validated as soon as it fills 8 of the last 10 messages.
- R10: Window slots not yet filled since reset count toward neither threshold, so fewer than 8 messages never validate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| msg_vld | input | 1 | One-cycle strobe marking a received message |
| msg_code | input | 6 | Code of the received message |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rd | input | 1 | Register read strobe; clears event bits at the edge |
| reg_rdata | output | 8 | Current register contents |
| val_code | output | 6 | Most recently accepted code |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `rst_n` is released in step with the clock. They also assume that `reg_rd` and `reg_wr` are single-cycle pulses, each of which counts as one access per edge. The random stimulus drives all inputs only at the falling edge. It draws most codes from a dominant code that changes now and then, which makes windows cross both thresholds in both directions. Strobes, reads and writes are issued on independent random cycles, so reads that coincide with events happen naturally, and a directed step forces one more such case.

// File: rtl/feac_pkg.sv
package feac_pkg;
  localparam int REG_W    = 8;
  localparam int BIT_SVAL = 0;  // validation event status
  localparam int BIT_EVAL = 1;  // validation interrupt enable
  localparam int BIT_SREM = 2;  // removal event status
  localparam int BIT_EREM = 3;  // removal interrupt enable
  localparam int BIT_FLAG = 4;  // code currently accepted
endpackage

// File: rtl/feac_window.sv
module feac_window #(
  parameter int CODE_W = 6,
  parameter int DEPTH  = 10,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [CODE_W-1:0] ref_i,
  output logic [CNT_W-1:0]  cnt_same_o,
  output logic [CNT_W-1:0]  cnt_diff_o
);
  localparam int STORE = DEPTH - 1;

  logic [CODE_W-1:0] hist_q [STORE];
  logic [CODE_W-1:0] hist_d [STORE];
  logic [STORE-1:0]  occ_q, occ_d;
  logic [DEPTH-1:0]  same_v, diff_v;

  // slot 0 of the window is the message arriving now
  assign same_v[0] = 1'b1;
  assign diff_v[0] = (code_i != ref_i);

  genvar k;
  generate
    for (k = 1; k < DEPTH; k++) begin : g_cmp
      assign same_v[k] = occ_q[k-1] && (hist_q[k-1] == code_i);
      assign diff_v[k] = occ_q[k-1] && (hist_q[k-1] != ref_i);
    end
  endgenerate

  always_comb begin
    cnt_same_o = '0;
    cnt_diff_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      cnt_same_o = cnt_same_o + CNT_W'(same_v[i]);
      cnt_diff_o = cnt_diff_o + CNT_W'(diff_v[i]);
    end
  end

  always_comb begin
    hist_d[0] = code_i;
    occ_d[0]  = 1'b1;
    for (int i = 1; i < STORE; i++) begin
      hist_d[i] = hist_q[i-1];
      occ_d[i]  = occ_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q <= '0;
      for (int i = 0; i < STORE; i++) hist_q[i] <= '0;
    end else if (push_i) begin
      occ_q <= occ_d;
      for (int i = 0; i < STORE; i++) hist_q[i] <= hist_d[i];
    end
  end

  // R9
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !push_i |=> $stable(occ_q));
  // R10
  fill_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |=> occ_q[0]);
endmodule

// File: rtl/feac_track.sv
module feac_track #(
  parameter int CODE_W  = 6,
  parameter int CNT_W   = 4,
  parameter int SET_THR = 8,
  parameter int CLR_THR = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [CNT_W-1:0]  cnt_same_i,
  input  logic [CNT_W-1:0]  cnt_diff_i,
  output logic              vld_o,
  output logic [CODE_W-1:0] code_o,
  output logic              ev_set_o,
  output logic              ev_clr_o
);
  logic              vld_q, vld_d;
  logic [CODE_W-1:0] code_q, code_d;

  always_comb begin
    vld_d    = vld_q;
    code_d   = code_q;
    ev_set_o = 1'b0;
    ev_clr_o = 1'b0;
    if (push_i) begin
      if (vld_q) begin
        if (cnt_diff_i >= CNT_W'(CLR_THR)) begin
          vld_d    = 1'b0;
          ev_clr_o = 1'b1;
        end
      end else if (cnt_same_i >= CNT_W'(SET_THR)) begin
        vld_d    = 1'b1;
        code_d   = code_i;
        ev_set_o = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      code_q <= '0;
    end else begin
      vld_q  <= vld_d;
      code_q <= code_d;
    end
  end

  assign vld_o  = vld_q;
  assign code_o = code_q;

  // R4
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_set_o |=> $stable(code_q));
  // R3
  excl_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_set_o && ev_clr_o));
  // R9
  flag_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !push_i |=> $stable(vld_q));
endmodule

// File: rtl/feac_csr.sv
module feac_csr
  import feac_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             ev_set_i,
  input  logic             ev_clr_i,
  input  logic             vld_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             irq_o
);
  logic en_val_q, en_val_d, en_rem_q, en_rem_d;
  logic st_val_q, st_val_d, st_rem_q, st_rem_d;

  always_comb begin
    en_val_d = en_val_q;
    en_rem_d = en_rem_q;
    if (wr_i) begin
      en_val_d = wdata_i[BIT_EVAL];
      en_rem_d = wdata_i[BIT_EREM];
    end
    // event set dominates a read clear in the same cycle
    st_val_d = ev_set_i | (st_val_q & ~rd_i);
    st_rem_d = ev_clr_i | (st_rem_q & ~rd_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_val_q <= 1'b0;
      en_rem_q <= 1'b0;
      st_val_q <= 1'b0;
      st_rem_q <= 1'b0;
    end else begin
      en_val_q <= en_val_d;
      en_rem_q <= en_rem_d;
      st_val_q <= st_val_d;
      st_rem_q <= st_rem_d;
    end
  end

  always_comb begin
    rdata_o           = '0;
    rdata_o[BIT_SVAL] = st_val_q;
    rdata_o[BIT_EVAL] = en_val_q;
    rdata_o[BIT_SREM] = st_rem_q;
    rdata_o[BIT_EREM] = en_rem_q;
    rdata_o[BIT_FLAG] = vld_i;
  end

  assign irq_o = (st_val_q & en_val_q) | (st_rem_q & en_rem_q);

  // R5
  val_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_set_i |=> st_val_q);
  // R6
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !ev_clr_i) |=> !st_rem_q);
  // R7
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> ($stable(en_val_q) && $stable(en_rem_q)));
  // R8
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(ev_set_i || ev_clr_i || wr_i));
endmodule

// File: rtl/feac_validator.sv
module feac_validator
  import feac_pkg::*;
#(
  parameter int CODE_W  = 6,
  parameter int DEPTH   = 10,
  parameter int SET_THR = 8,
  parameter int CLR_THR = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msg_vld,
  input  logic [CODE_W-1:0] msg_code,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              reg_rd,
  output logic [REG_W-1:0]  reg_rdata,
  output logic [CODE_W-1:0] val_code,
  output logic              irq
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0]  cnt_same, cnt_diff;
  logic [CODE_W-1:0] acc_code;
  logic              acc_vld, ev_set, ev_clr;

  feac_window #(.CODE_W(CODE_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_window (
    .clk(clk), .rst_n(rst_n), .push_i(msg_vld), .code_i(msg_code),
    .ref_i(acc_code), .cnt_same_o(cnt_same), .cnt_diff_o(cnt_diff)
  );

  feac_track #(.CODE_W(CODE_W), .CNT_W(CNT_W), .SET_THR(SET_THR),
               .CLR_THR(CLR_THR)) u_track (
    .clk(clk), .rst_n(rst_n), .push_i(msg_vld), .code_i(msg_code),
    .cnt_same_i(cnt_same), .cnt_diff_i(cnt_diff), .vld_o(acc_vld),
    .code_o(acc_code), .ev_set_o(ev_set), .ev_clr_o(ev_clr)
  );

  feac_csr u_csr (
    .clk(clk), .rst_n(rst_n), .rd_i(reg_rd), .wr_i(reg_wr),
    .wdata_i(reg_wdata), .ev_set_i(ev_set), .ev_clr_i(ev_clr),
    .vld_i(acc_vld), .rdata_o(reg_rdata), .irq_o(irq)
  );

  assign val_code = acc_code;

  // R2
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_rdata[BIT_FLAG]) |-> $past(msg_vld));
  // R3
  flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reg_rdata[BIT_FLAG]) |-> reg_rdata[BIT_SREM]);
endmodule

// File: tb/feac_validator_tb.sv
`timescale 1ns/1ps
module feac_validator_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       msg_vld, reg_wr, reg_rd;
  logic [5:0] msg_code;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic [5:0] val_code;
  logic       irq;

  always #2 clk = ~clk;

  feac_validator u_dut (
    .clk(clk), .rst_n(rst_n), .msg_vld(msg_vld), .msg_code(msg_code),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .val_code(val_code), .irq(irq)
  );

  int  n_chk = 0, n_bad = 0;
  bit  done = 0;

  // reference model
  logic [5:0] m_hist [10];
  bit         m_occ  [10];
  bit         m_vld, m_en_val, m_en_rem, m_s_val, m_s_rem;
  logic [5:0] m_code;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] m_reg();
    return {3'b000, m_vld, m_en_rem, m_s_rem, m_en_val, m_s_val};
  endfunction

  function automatic bit m_irq();
    return (m_s_val && m_en_val) || (m_s_rem && m_en_rem);
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 10; i++) begin m_hist[i] = '0; m_occ[i] = 0; end
    m_vld = 0; m_code = '0; m_en_val = 0; m_en_rem = 0; m_s_val = 0; m_s_rem = 0;
  endtask

  task automatic m_step(bit s, logic [5:0] c, bit r, bit w, logic [7:0] wd);
    bit ev_v = 0, ev_r = 0;
    int same = 0, diff = 0;
    if (s) begin
      for (int i = 9; i > 0; i--) begin m_hist[i] = m_hist[i-1]; m_occ[i] = m_occ[i-1]; end
      m_hist[0] = c; m_occ[0] = 1;
      for (int i = 0; i < 10; i++) begin
        if (m_occ[i] && m_hist[i] == c) same++;
        if (m_occ[i] && m_hist[i] != m_code) diff++;
      end
      if (m_vld) begin
        if (diff >= 3) begin m_vld = 0; ev_r = 1; end
      end else if (same >= 8) begin
        m_vld = 1; m_code = c; ev_v = 1;
      end
    end
    if (r) begin m_s_val = 0; m_s_rem = 0; end
    if (ev_v) m_s_val = 1;
    if (ev_r) m_s_rem = 1;
    if (w) begin m_en_val = wd[1]; m_en_rem = wd[3]; end
  endtask

  task automatic cyc(bit s, logic [5:0] c, bit r, bit w, logic [7:0] wd);
    msg_vld = s; msg_code = c; reg_rd = r; reg_wr = w; reg_wdata = wd;
    @(posedge clk);
    m_step(s, c, r, w, wd);
    @(negedge clk);
    msg_vld = 0; reg_rd = 0; reg_wr = 0;
    chk("R2 R3 R5 R6 R7 register", {24'd0, reg_rdata}, {24'd0, m_reg()});
    chk("R4 val_code", {26'd0, val_code}, {26'd0, m_code});
    chk("R8 irq", {31'd0, irq}, {31'd0, m_irq()});
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 0; msg_vld = 0; msg_code = '0; reg_rd = 0; reg_wr = 0; reg_wdata = '0;
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 reset register", {24'd0, reg_rdata}, 32'h00);
    chk("R1 reset val_code", {26'd0, val_code}, 32'h0);
    chk("R1 reset irq", {31'd0, irq}, 32'h0);
    // R10: seven messages cannot validate
    for (int i = 0; i < 7; i++) cyc(1, 6'd5, 0, 0, 8'h00);
    chk("R10 early flag", {31'd0, reg_rdata[4]}, 32'h0);
    cyc(1, 6'd5, 0, 0, 8'h00);
    chk("R2 flag after eighth", {31'd0, reg_rdata[4]}, 32'h1);
    chk("R5 status without enable", {31'd0, reg_rdata[0]}, 32'h1);
    chk("R4 accepted code", {26'd0, val_code}, 32'd5);
    chk("R8 masked irq", {31'd0, irq}, 32'h0);
    for (int i = 0; i < 5; i++) cyc(0, 6'd33, 0, 0, 8'h00);
    chk("R9 idle keeps flag", {31'd0, reg_rdata[4]}, 32'h1);
    cyc(0, 6'd0, 0, 1, 8'hFF);
    chk("R7 write all ones", {24'd0, reg_rdata}, 32'h1B);
    chk("R8 irq enabled", {31'd0, irq}, 32'h1);
    cyc(0, 6'd0, 1, 0, 8'h00);
    chk("R6 read clears", {24'd0, reg_rdata}, 32'h1A);
    cyc(1, 6'd9, 0, 0, 8'h00);
    cyc(1, 6'd9, 0, 0, 8'h00);
    chk("R3 two differing keep flag", {31'd0, reg_rdata[4]}, 32'h1);
    cyc(1, 6'd9, 0, 0, 8'h00);
    chk("R3 removal", {24'd0, reg_rdata}, 32'h0E);
    chk("R4 code held after removal", {26'd0, val_code}, 32'd5);
    chk("R8 removal irq", {31'd0, irq}, 32'h1);
    for (int i = 0; i < 4; i++) cyc(1, 6'd9, 0, 0, 8'h00);
    chk("R9 not yet revalidated", {31'd0, reg_rdata[4]}, 32'h0);
    cyc(1, 6'd9, 1, 0, 8'h00);
    chk("R6 set wins over read", {24'd0, reg_rdata}, 32'h1B);
    chk("R9 revalidated code", {26'd0, val_code}, 32'd9);
    cyc(0, 6'd0, 0, 1, 8'hF5);
    chk("R7 ignored bits", {24'd0, reg_rdata}, 32'h11);
    // random phase
    begin
      logic [5:0] dom = 6'd12;
      for (int n = 0; n < 4000; n++) begin
        bit s = ($urandom % 2) == 0;
        bit r = ($urandom % 8) == 0;
        bit w = ($urandom % 16) == 0;
        logic [5:0] c;
        if (($urandom % 40) == 0) dom = 6'($urandom);
        c = (($urandom % 5) == 0) ? 6'($urandom) : dom;
        cyc(s, c, r, w, 8'($urandom));
      end
    end
    done = 1;
    summary();
    $finish;
  end
endmodule